// File: doc/BRIEF.md
# Four-Channel Memory Copy and Fill Engine

This block moves blocks of memory on behalf of software. It has four independent channels. Each channel holds a source address, a destination address and a control word, plus a 32-bit constant that it can use as the source when filling a region. Software programs the addresses, then writes a control word with the enable bit set. The engine then moves the requested number of 16-bit or 32-bit units over a single valid/ready memory port. Each unit is a read followed by a write. When the last unit is written, the channel clears its busy bit. If asked, it also pulses its completion interrupt.

Only one unit is on the bus at a time. Before each unit, the lowest-numbered channel that is ready to run takes the bus. A start-timing field and a repeat flag are stored and read back, but any non-zero timing leaves the channel armed and idle. Software can stop a channel with a two-step control sequence, and the channel then halts at the next unit boundary. Channel 0 also guards its source range: a start whose source range touches the I/O page or high memory is refused.

Top module: `mdma_ctrl`

## Requirements
- R1: Register map (byte offsets, word access). Channel n uses three registers: source at 12·n, destination at 12·n+4 and control at 12·n+8. Its fill constant is at 0x40+4·n. Reads return the stored values. Control reads back as {busy[31], irq_en[30], timing[29:27], wide[26], repeat[25], src_mode[24:23], spare[22:21], remaining count[20:0]}, and bit 31 is live.
- R2: A control write with bit 31 set, a non-zero count and timing 0 starts the channel. Bit 31 reads 1 until the last unit has been written, and then reads 0.
- R3: With bit 30 set, irq[n] is high for exactly one cycle, in the first cycle in which bit 31 reads 0 after a normal completion. There is no pulse when bit 30 is clear or when the channel was stopped.
- R4: Bit 26 selects the unit: 1 is 32 bits with mem_size=1, and 0 is 16 bits with mem_size=0, data on bits 15:0 and upper write bits zero. Bits 20:0 count units.
- R5: Source mode 00 adds the unit size after each unit, and 01 subtracts it. The destination always advances by the unit size.
- R6: Source mode 10 or 11 is a fill. No read is issued, and every unit writes the channel's fill constant (its low half for 16-bit units).
- R7: A start with count 0 issues no bus access, leaves bit 31 at 0, and pulses irq[n] in the next cycle if bit 30 is set.
- R8: Each unit is one read (mem_we=0) followed by one write (mem_we=1). Request, address, direction and write data stay stable until mem_ready.
- R9: When several channels can run, each unit goes to the lowest-numbered one.
- R10: A start with non-zero timing sets bit 31 but never moves data, even after the timing field is later cleared.
- R11: A control write with bit 31 clear stops a busy channel only if its stored timing and repeat were already zero before that write. Otherwise it only updates those fields. A unit that is on the bus is finished first. A stop gives no interrupt.
- R12: While bit 31 is set, writes to source, destination, count, unit size or source mode are ignored.
- R13: Channel 0 with source mode 00 or 01 refuses a start if the top address byte of the source, or of the range end (source ± count·unit bytes), equals 0x04 or is at least 0x08. It then sets ch0_err, and bit 31 stays 0 with no interrupt. The next accepted start on channel 0 clears ch0_err. Fills and channels 1 to 3 are not checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_size | output | 1 | 1 = 32-bit unit, 0 = 16-bit unit |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data (16-bit units on bits 15:0) |
| mem_ready | input | 1 | Memory accepts or completes the access |
| irq | output | 4 | Per-channel completion pulse |
| ch0_err | output | 1 | Channel 0 refused a source range |

## Verification
A wrong address step or a wrong choice of data source shows up as bad data at a destination word. That word is written within a few cycles of the unit in question, and the bench compares it against a snapshot once the channel finishes. A stuck busy flag or a lost stop request appears at once as bit 31 reading back wrong, or as an interrupt that is missing or extra. A wrong grant reorders the completion interrupts, which the bench detects in the first run where several channels compete for the bus. Protocol slips, such as a request dropped or changed before mem_ready, fail on the very next cycle.

// File: rtl/mdma_pkg.sv
// Shared control-word layout and engine state type for the memory copy engine.
package mdma_pkg;
    localparam int CNT_W   = 21;   // unit count field width, bits 20:0
    localparam int B_EN    = 31;   // enable / busy
    localparam int B_IE    = 30;   // completion interrupt request
    localparam int B_WIDE  = 26;   // 1 = 32-bit units
    localparam int B_RPT   = 25;   // repeat flag (stored only)

    typedef enum logic [1:0] {
        SM_INC  = 2'b00,
        SM_DEC  = 2'b01,
        SM_FIX  = 2'b10,
        SM_FIX2 = 2'b11
    } src_mode_e;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'b00,
        ENG_RD   = 2'b01,
        ENG_WR   = 2'b10
    } eng_state_e;
endpackage

// File: rtl/mdma_chan.sv
// One channel's register set and progress state.
// Assumes writes to source/destination/count are only honoured while idle and
// that unit_done is pulsed by the engine once per unit moved for this channel.
module mdma_chan
    import mdma_pkg::*;
#(
    parameter int AW          = 32,
    parameter bit CHECK_RANGE = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_src,
    input  logic          wr_dst,
    input  logic          wr_ctl,
    input  logic          wr_fill,
    input  logic [31:0]   wdata,
    input  logic          active,
    input  logic          unit_done,
    output logic [AW-1:0] src_o,
    output logic [AW-1:0] dst_o,
    output logic [31:0]   fill_o,
    output logic [31:0]   ctl_o,
    output logic          busy_o,
    output logic          run_o,
    output logic          wide_o,
    output logic          fixed_o,
    output logic          irq_o,
    output logic          err_o
);
    localparam int TOP = AW - 8;

    logic [AW-1:0]    src_q, dst_q;
    logic [31:0]      fill_q;
    logic [CNT_W-1:0] cnt_q;
    logic [2:0]       tm_q;
    logic [1:0]       sm_q, rsv_q;
    logic             busy_q, go_q, stop_pend, ie_q, rpt_q, wide_q, irq_q, err_q;

    logic [AW-1:0]    step, span, end_a, next_src;
    logic             range_bad;

    // Per-unit address step and the source range end used by the start check.
    always_comb begin
        step  = wide_q ? AW'(4) : AW'(2);
        span  = AW'(wdata[CNT_W-1:0]) << (wdata[B_WIDE] ? 2 : 1);
        case (src_mode_e'(wdata[24:23]))
            SM_INC:  end_a = src_q + span;
            SM_DEC:  end_a = src_q - span;
            default: end_a = src_q;
        endcase
        range_bad = CHECK_RANGE && !wdata[24] &&
                    (src_q[AW-1:TOP] == 8'h04 || src_q[AW-1:TOP] >= 8'h08 ||
                     end_a[AW-1:TOP] == 8'h04 || end_a[AW-1:TOP] >= 8'h08);
        case (src_mode_e'(sm_q))
            SM_INC:  next_src = src_q + step;
            SM_DEC:  next_src = src_q - step;
            default: next_src = src_q;
        endcase
    end

    // Register writes, start and stop handling, and per-unit progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0; dst_q <= '0; fill_q <= '0; cnt_q <= '0;
            tm_q <= '0; sm_q <= '0; rsv_q <= '0; ie_q <= 1'b0; rpt_q <= 1'b0;
            wide_q <= 1'b0; busy_q <= 1'b0; go_q <= 1'b0; stop_pend <= 1'b0;
            irq_q <= 1'b0; err_q <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (wr_fill) fill_q <= wdata;
            if (!busy_q) begin
                if (wr_src) src_q <= AW'(wdata);
                if (wr_dst) dst_q <= AW'(wdata);
                if (wr_ctl) begin
                    ie_q   <= wdata[B_IE];
                    tm_q   <= wdata[29:27];
                    wide_q <= wdata[B_WIDE];
                    rpt_q  <= wdata[B_RPT];
                    sm_q   <= wdata[24:23];
                    rsv_q  <= wdata[22:21];
                    cnt_q  <= wdata[CNT_W-1:0];
                    if (wdata[B_EN]) begin
                        if (range_bad) begin
                            err_q <= 1'b1;
                        end else begin
                            err_q <= 1'b0;
                            if (wdata[CNT_W-1:0] == '0) begin
                                irq_q <= wdata[B_IE];
                            end else begin
                                busy_q <= 1'b1;
                                go_q   <= (wdata[29:27] == 3'd0);
                            end
                        end
                    end
                end
            end else begin
                if (unit_done) begin
                    src_q <= next_src;
                    dst_q <= dst_q + step;
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == CNT_W'(1) || stop_pend) begin
                        busy_q    <= 1'b0;
                        go_q      <= 1'b0;
                        stop_pend <= 1'b0;
                        irq_q     <= ie_q && !stop_pend;
                    end
                end
                if (wr_ctl) begin
                    ie_q  <= wdata[B_IE];
                    tm_q  <= wdata[29:27];
                    rpt_q <= wdata[B_RPT];
                    if (!wdata[B_EN] && tm_q == 3'd0 && !rpt_q) begin
                        irq_q <= 1'b0;
                        if (active && !unit_done) begin
                            stop_pend <= 1'b1;
                        end else begin
                            busy_q    <= 1'b0;
                            go_q      <= 1'b0;
                            stop_pend <= 1'b0;
                        end
                    end
                end
            end
        end
    end

    assign src_o   = src_q;
    assign dst_o   = dst_q;
    assign fill_o  = fill_q;
    assign ctl_o   = {busy_q, ie_q, tm_q, wide_q, rpt_q, sm_q, rsv_q, cnt_q};
    assign busy_o  = busy_q;
    assign run_o   = busy_q && go_q && !stop_pend;
    assign wide_o  = wide_q;
    assign fixed_o = sm_q[1];
    assign irq_o   = irq_q;
    assign err_o   = err_q;
endmodule

// File: rtl/mdma_prio.sv
// Fixed-priority pick: lowest-numbered requesting channel wins.
module mdma_prio #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] gnt,
    output logic          any
);
    // Scan from the top so the lowest index is assigned last.
    always_comb begin
        gnt = '0;
        any = |req;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) gnt = IW'(i);
        end
    end
endmodule

// File: rtl/mdma_engine.sv
// Bus sequencer: one unit per grant, read then write (write only for fills).
// Assumes sel_* inputs show the granted channel while idle and the owning
// channel otherwise, and stay stable for the whole unit.
module mdma_engine
    import mdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          any_req,
    input  logic [IW-1:0] gnt,
    input  logic [AW-1:0] sel_src,
    input  logic [AW-1:0] sel_dst,
    input  logic [31:0]   sel_fill,
    input  logic          sel_wide,
    input  logic          sel_fixed,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_ready,
    output logic          idle,
    output logic [IW-1:0] cur,
    output logic          unit_done,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_size,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata
);
    eng_state_e  state;
    logic [31:0] data_q;

    // Unit sequencing: claim a channel, optionally read, then write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ENG_IDLE;
            cur    <= '0;
            data_q <= '0;
        end else begin
            case (state)
                ENG_IDLE: if (any_req) begin
                    cur <= gnt;
                    if (sel_fixed) begin
                        data_q <= sel_fill;
                        state  <= ENG_WR;
                    end else begin
                        state  <= ENG_RD;
                    end
                end
                ENG_RD: if (mem_ready) begin
                    data_q <= mem_rdata;
                    state  <= ENG_WR;
                end
                ENG_WR: if (mem_ready) state <= ENG_IDLE;
                default: state <= ENG_IDLE;
            endcase
        end
    end

    // Bus drive derived from the state and the owning channel.
    always_comb begin
        idle      = (state == ENG_IDLE);
        mem_req   = !idle;
        mem_we    = (state == ENG_WR);
        mem_size  = sel_wide;
        mem_addr  = mem_we ? sel_dst : sel_src;
        mem_wdata = sel_wide ? data_q : {16'h0, data_q[15:0]};
        unit_done = mem_we && mem_ready;
    end
endmodule

// File: rtl/mdma_ctrl.sv
// Top: register decode, channel array, priority pick and bus engine.
// Assumes word-aligned register accesses; unmatched addresses read as zero.
module mdma_ctrl
    import mdma_pkg::*;
#(
    parameter int          NUM_CH    = 4,
    parameter int          AW        = 32,
    parameter int          RAW       = 8,
    parameter logic [7:0]  FILL_BASE = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [RAW-1:0]    reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_size,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ready,
    output logic [NUM_CH-1:0] irq,
    output logic              ch0_err
);
    localparam int IW     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int STRIDE = 12;

    logic [AW-1:0] src_a [NUM_CH];
    logic [AW-1:0] dst_a [NUM_CH];
    logic [31:0]   fill_a[NUM_CH];
    logic [31:0]   ctl_a [NUM_CH];
    logic [NUM_CH-1:0] busy_v, run_v, wide_v, fixed_v, err_v, done_v, act_v;
    logic [IW-1:0] gnt, cur_ch, sel;
    logic          any_req, eng_idle, unit_done;

    generate
        for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
            mdma_chan #(.AW(AW), .CHECK_RANGE(n == 0)) u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_src   (reg_wr && reg_addr == RAW'(STRIDE * n)),
                .wr_dst   (reg_wr && reg_addr == RAW'(STRIDE * n + 4)),
                .wr_ctl   (reg_wr && reg_addr == RAW'(STRIDE * n + 8)),
                .wr_fill  (reg_wr && reg_addr == RAW'(FILL_BASE + 4 * n)),
                .wdata    (reg_wdata),
                .active   (act_v[n]),
                .unit_done(done_v[n]),
                .src_o    (src_a[n]),
                .dst_o    (dst_a[n]),
                .fill_o   (fill_a[n]),
                .ctl_o    (ctl_a[n]),
                .busy_o   (busy_v[n]),
                .run_o    (run_v[n]),
                .wide_o   (wide_v[n]),
                .fixed_o  (fixed_v[n]),
                .irq_o    (irq[n]),
                .err_o    (err_v[n])
            );
            assign act_v[n]  = (!eng_idle || any_req) && sel == IW'(n);
            assign done_v[n] = unit_done && cur_ch == IW'(n);
        end
    endgenerate

    mdma_prio #(.N(NUM_CH), .IW(IW)) u_prio (
        .req (run_v),
        .gnt (gnt),
        .any (any_req)
    );

    assign sel = eng_idle ? gnt : cur_ch;

    mdma_engine #(.AW(AW), .IW(IW)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_req  (any_req),
        .gnt      (gnt),
        .sel_src  (src_a[sel]),
        .sel_dst  (dst_a[sel]),
        .sel_fill (fill_a[sel]),
        .sel_wide (wide_v[sel]),
        .sel_fixed(fixed_v[sel]),
        .mem_rdata(mem_rdata),
        .mem_ready(mem_ready),
        .idle     (eng_idle),
        .cur      (cur_ch),
        .unit_done(unit_done),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_size (mem_size),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata)
    );

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            if (reg_addr == RAW'(STRIDE * n))         reg_rdata = 32'(src_a[n]);
            if (reg_addr == RAW'(STRIDE * n + 4))     reg_rdata = 32'(dst_a[n]);
            if (reg_addr == RAW'(STRIDE * n + 8))     reg_rdata = ctl_a[n];
            if (reg_addr == RAW'(FILL_BASE + 4 * n))  reg_rdata = fill_a[n];
        end
    end

    assign ch0_err = err_v[0];
endmodule

// File: rtl/mdma_ctrl_chk.sv
// Protocol and state checks for mdma_ctrl, attached by bind.
module mdma_ctrl_chk #(
    parameter int N  = 4,
    parameter int AW = 32,
    parameter int IW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic [N-1:0]  irq,
    input logic [N-1:0]  busy,
    input logic          ch0_err,
    input logic [IW-1:0] cur
);
    a_r8_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    a_r8_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_ready |=> mem_req && mem_we);

    a_r2_owner_is_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy[cur]);

    a_r13_err_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ch0_err |-> !busy[0]);

    generate
        for (genvar i = 0; i < N; i++) begin : g_irq
            a_r3_irq_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
                irq[i] |-> !busy[i]);
        end
    endgenerate
endmodule

bind mdma_ctrl mdma_ctrl_chk #(.N(NUM_CH), .AW(AW), .IW(IW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_ready(mem_ready),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .irq      (irq),
    .busy     (busy_v),
    .ch0_err  (ch0_err),
    .cur      (cur_ch)
);

// File: tb/mdma_ctrl_tb.sv
`timescale 1ns/1ps
module mdma_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_size;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ready = 1'b0;
    logic [3:0]  irq;
    logic        ch0_err;

    int n_chk = 0, n_err = 0;
    int irq_cnt[4];
    int order[64];
    int olen = 0;
    int n_xfer = 0, n_wr = 0;
    bit stall = 1'b0;
    logic [31:0] mem [0:255];
    logic [31:0] snap[0:255];

    always #10 clk = ~clk;

    mdma_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .irq(irq), .ch0_err(ch0_err)
    );

    // Memory model: 1 KB, 16-bit units on bits 15:0.
    assign mem_rdata = mem_size ? mem[mem_addr[9:2]] :
        {16'h0, mem_addr[1] ? mem[mem_addr[9:2]][31:16] : mem[mem_addr[9:2]][15:0]};

    always @(posedge clk) begin
        if (mem_req && mem_ready) n_xfer++;
        if (mem_req && mem_we && mem_ready) begin
            n_wr++;
            if (mem_size) mem[mem_addr[9:2]] <= mem_wdata;
            else if (mem_addr[1]) mem[mem_addr[9:2]][31:16] <= mem_wdata[15:0];
            else mem[mem_addr[9:2]][15:0] <= mem_wdata[15:0];
        end
        for (int i = 0; i < 4; i++) begin
            if (rst_n && irq[i]) begin
                irq_cnt[i]++;
                if (olen < 64) begin order[olen] = i; olen++; end
            end
        end
    end

    always @(negedge clk) mem_ready = !stall && ($urandom_range(3) != 0);

    function automatic logic [31:0] mk_ctl(bit en, bit ie, logic [2:0] tm, bit wide,
                                           bit rpt, logic [1:0] sm, int cnt);
        return {en, ie, tm, wide, rpt, sm, 2'b00, 21'(cnt)};
    endfunction

    function automatic logic [31:0] unit_of(input logic [31:0] w, input logic [31:0] a, input bit wide);
        if (wide) return w;
        return {16'h0, a[1] ? w[31:16] : w[15:0]};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle(input int ch, string tag);
        logic [31:0] c;
        for (int k = 0; k < 4000; k++) begin
            rd(8'(12 * ch + 8), c);
            if (!c[31]) return;
        end
        chk({tag, " channel never finished"}, 32'd1, 32'd0);
    endtask

    task automatic run_xfer(input int ch, input logic [31:0] s, input logic [31:0] d, input int cnt,
                            input bit wide, input logic [1:0] sm, input bit ie,
                            input logic [31:0] fillv, string tag);
        int bad = 0, x0, i0, ub;
        logic [31:0] ea, sa, ev, av;
        for (int i = 0; i < 256; i++) snap[i] = mem[i];
        ub = wide ? 4 : 2;
        wr(8'h40 + 8'(4 * ch), fillv);
        wr(8'(12 * ch), s);
        wr(8'(12 * ch + 4), d);
        x0 = n_xfer; i0 = irq_cnt[ch];
        wr(8'(12 * ch + 8), mk_ctl(1, ie, 3'd0, wide, 0, sm, cnt));
        wait_idle(ch, tag);
        repeat (2) @(negedge clk);
        for (int k = 0; k < cnt; k++) begin
            ea = d + 32'(k * ub);
            sa = (sm == 2'b00) ? s + 32'(k * ub) : s - 32'(k * ub);
            ev = sm[1] ? (wide ? fillv : {16'h0, fillv[15:0]}) : unit_of(snap[sa[9:2]], sa, wide);
            av = unit_of(mem[ea[9:2]], ea, wide);
            if (av !== ev) begin
                if (bad == 0) $display("FAIL %s data unit %0d: actual %h expected %h", tag, k, av, ev);
                bad++;
            end
        end
        n_chk++;
        if (bad != 0) n_err++;
        chk({tag, " R8 bus access count"}, 32'(n_xfer - x0), 32'(sm[1] ? cnt : 2 * cnt));
        chk({tag, " R3 irq count"}, 32'(irq_cnt[ch] - i0), 32'(ie));
    endtask

    initial begin
        logic [31:0] v;
        int x0, i0, w0, o0;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) mem[i] = (32'(i) * 32'h01030507) ^ 32'h5EED0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int c = 0; c < 4; c++) begin
            rd(8'(12 * c + 8), v);
            chk("R1 reset control", v, 32'h0);
        end
        chk("R1 reset irq/err/req", {27'h0, irq, ch0_err} | {31'h0, mem_req}, 32'h0);

        // R1 register readback
        wr(8'd24, 32'h0000_0120); wr(8'd28, 32'h0000_0344); wr(8'h4C, 32'hCAFE_F00D);
        rd(8'd24, v); chk("R1 src readback", v, 32'h0000_0120);
        rd(8'd28, v); chk("R1 dst readback", v, 32'h0000_0344);
        rd(8'h4C, v); chk("R1 fill readback", v, 32'hCAFE_F00D);

        // R2 R4 R5: copies in both directions and both unit sizes
        run_xfer(0, 32'h000, 32'h200, 8, 1, 2'b00, 1, 32'h0, "R2 R5 copy32 inc");
        run_xfer(1, 32'h010, 32'h240, 7, 0, 2'b00, 1, 32'h0, "R4 copy16 inc");
        run_xfer(2, 32'h0FC, 32'h280, 5, 1, 2'b01, 0, 32'h0, "R5 copy32 dec");
        run_xfer(3, 32'h0C2, 32'h2C0, 6, 0, 2'b01, 1, 32'h0, "R5 copy16 dec");
        // R6 fills
        run_xfer(0, 32'h0400_0000, 32'h300, 6, 1, 2'b10, 1, 32'hA5A5_5A5A, "R6 fill32");
        run_xfer(1, 32'h000, 32'h342, 5, 0, 2'b11, 0, 32'h1234_BEEF, "R6 fill16");

        // R7 count zero
        x0 = n_xfer; i0 = irq_cnt[2];
        wr(8'd32, mk_ctl(1, 1, 3'd0, 1, 0, 2'b00, 0));
        rd(8'd32, v); chk("R7 count0 bit31", {31'h0, v[31]}, 32'h0);
        repeat (3) @(negedge clk);
        chk("R7 count0 irq", 32'(irq_cnt[2] - i0), 32'd1);
        chk("R7 count0 no bus", 32'(n_xfer - x0), 32'd0);

        // R13 channel 0 range guard
        i0 = irq_cnt[0];
        wr(8'd0, 32'h0400_0000);
        wr(8'd8, mk_ctl(1, 1, 3'd0, 1, 0, 2'b00, 4));
        rd(8'd8, v);
        chk("R13 io page start refused", {30'h0, ch0_err, v[31]}, 32'h2);
        wr(8'd0, 32'h07FF_FFFC);
        wr(8'd8, mk_ctl(1, 1, 3'd0, 1, 0, 2'b00, 2));
        rd(8'd8, v);
        chk("R13 range end at 0x08 refused", {30'h0, ch0_err, v[31]}, 32'h2);
        wr(8'd0, 32'h0500_0002);
        wr(8'd8, mk_ctl(1, 1, 3'd0, 0, 0, 2'b01, 2));
        rd(8'd8, v);
        chk("R13 decrement into io page refused", {30'h0, ch0_err, v[31]}, 32'h2);
        repeat (2) @(negedge clk);
        chk("R13 no irq on refusal", 32'(irq_cnt[0] - i0), 32'd0);
        run_xfer(0, 32'h000, 32'h3C0, 1, 1, 2'b00, 0, 32'h0, "R13 clean start");
        chk("R13 err cleared", {31'h0, ch0_err}, 32'h0);
        wr(8'd12, 32'h0400_0000); wr(8'd16, 32'h3D0);
        wr(8'd20, mk_ctl(1, 0, 3'd0, 1, 0, 2'b00, 1));
        wait_idle(1, "R13 ch1 unchecked");
        chk("R13 ch1 not guarded", {31'h0, ch0_err}, 32'h0);

        // R10 R12 R11: armed channel with timing set
        wr(8'd36, 32'h000); wr(8'd40, 32'h380);
        x0 = n_xfer; i0 = irq_cnt[3];
        wr(8'd44, mk_ctl(1, 1, 3'd3, 1, 0, 2'b00, 4));
        repeat (20) @(negedge clk);
        rd(8'd44, v);
        chk("R10 armed stays busy", {31'h0, v[31]}, 32'h1);
        chk("R10 armed no bus", 32'(n_xfer - x0), 32'd0);
        wr(8'd36, 32'h111);
        rd(8'd36, v); chk("R12 src write ignored", v, 32'h000);
        wr(8'd44, mk_ctl(1, 1, 3'd3, 0, 0, 2'b01, 9));
        rd(8'd44, v); chk("R12 count/size/mode ignored", {8'h0, v[26], v[24:23], v[20:0]}, 32'h0080_0004);
        wr(8'd44, mk_ctl(0, 1, 3'd0, 1, 0, 2'b00, 4));
        rd(8'd44, v); chk("R11 stop with timing set ignored", {31'h0, v[31]}, 32'h1);
        repeat (10) @(negedge clk);
        chk("R10 timing cleared still idle", 32'(n_xfer - x0), 32'd0);
        wr(8'd44, 32'h0);
        rd(8'd44, v); chk("R11 second stop", {31'h0, v[31]}, 32'h0);
        repeat (2) @(negedge clk);
        chk("R11 no irq on stop", 32'(irq_cnt[3] - i0), 32'd0);

        // R11 stop mid-unit waits for the unit boundary
        stall = 1'b1;
        wr(8'd12, 32'h000); wr(8'd16, 32'h200);
        i0 = irq_cnt[1]; w0 = n_wr;
        wr(8'd20, mk_ctl(1, 1, 3'd0, 1, 1, 2'b00, 20));
        wr(8'd20, 32'h0);
        rd(8'd20, v); chk("R11 stop with repeat set ignored", {31'h0, v[31]}, 32'h1);
        wr(8'd20, 32'h0);
        rd(8'd20, v); chk("R11 busy until unit boundary", {31'h0, v[31]}, 32'h1);
        stall = 1'b0;
        wait_idle(1, "R11 abort");
        repeat (4) @(negedge clk);
        chk("R11 one unit after stop", 32'(n_wr - w0), 32'd1);
        chk("R11 abort gives no irq", 32'(irq_cnt[1] - i0), 32'd0);

        // R9 priority: lowest channel wins each unit
        stall = 1'b1;
        for (int c = 3; c >= 1; c--) begin
            wr(8'(12 * c), 32'h000);
            wr(8'(12 * c + 4), 32'h200 + 32'(c * 16));
        end
        o0 = olen;
        wr(8'd44, mk_ctl(1, 1, 3'd0, 1, 0, 2'b00, 3));
        wr(8'd32, mk_ctl(1, 1, 3'd0, 1, 0, 2'b00, 3));
        wr(8'd20, mk_ctl(1, 1, 3'd0, 1, 0, 2'b00, 3));
        stall = 1'b0;
        wait_idle(3, "R9 prio");
        repeat (3) @(negedge clk);
        chk("R9 completion order", {8'h0, 8'(order[o0]), 8'(order[o0 + 1]), 8'(order[o0 + 2])},
            32'h0001_0203);

        // R2 R4 R5 R6 random transfers with random memory wait states
        for (int r = 0; r < 10; r++) begin
            int ch, cnt;
            bit wide;
            logic [1:0] sm;
            ch   = $urandom_range(3);
            cnt  = $urandom_range(8, 1);
            wide = $urandom_range(1);
            sm   = 2'($urandom_range(2));
            run_xfer(ch, 32'h080 + 32'($urandom_range(31)) * (wide ? 4 : 2),
                     32'h200 + 32'($urandom_range(31)) * 4 + (wide ? 0 : 32'($urandom_range(1)) * 2),
                     cnt, wide, sm, $urandom_range(1), $urandom(), "R5 R6 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule